// File: doc/BRIEF.md
# Handshake Multi-Bit Value Synchronizer

This block moves a multi-bit binary value from a source clock domain into an unrelated destination clock domain. It does not rely on Gray coding, so the value may jump to any pattern between two transfers. The source control copies the current input into a holding register. It then raises a request level. That request crosses into the destination through a two-flop synchronizer.

When the destination sees the synchronized request, it loads the held value into its output register and pulses a valid strobe for one cycle. It also raises an acknowledge level, which crosses back through a second two-flop synchronizer. The source drops its request only after it sees the acknowledge. It takes a new sample once the acknowledge has fallen again, which closes the four-phase loop. Between transfers the destination keeps its last value.

Top module: `hs_value_sync`

## Requirements
- R1: While `rst_ni` is low, `dst_valid_o` is 0 and `dst_value_o` is all zeros.
- R2: The holding register keeps its value for every source cycle in which the request is raised.
- R3: `dst_valid_o` is never high for two destination cycles in a row.
- R4: Each `dst_valid_o` pulse carries on `dst_value_o` the value of `src_value_i` at the rising source edge where `src_take_o` was high. Deliveries arrive in capture order, and none is lost or repeated.
- R5: Transfers are exact for arbitrary value sequences: single steps, scattered jumps, and alternation between all-zeros and all-ones.
- R6: At least two rising destination edges separate a capture from its `dst_valid_o` pulse.
- R7: A new capture (`src_take_o` high) happens only after the previous captured value has been delivered, and only while the synchronized acknowledge is low.
- R8: `dst_value_o` changes only in a cycle where `dst_valid_o` is high, and it holds its value otherwise.
- R9: R4 through R8 hold whether the destination clock is faster than, slower than, or equal in frequency to the source clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk_i | input | 1 | Source domain clock |
| dst_clk_i | input | 1 | Destination domain clock |
| rst_ni | input | 1 | Active-low asynchronous reset, both domains |
| src_value_i | input | W | Value sampled in the source domain |
| src_take_o | output | 1 | High in the source cycle whose rising edge captures `src_value_i` |
| dst_value_o | output | W | Last value delivered into the destination domain |
| dst_valid_o | output | 1 | One-cycle strobe marking a new `dst_value_o` |

## Verification
The source value is driven in three ways.
- A step-by-one count, which is the case a Gray-coded path would also handle.
- A multiply-and-add walk that visits all 32 codes with large jumps. Only a design that carries the whole word intact can follow it.
- A toggle between all-zeros and all-ones, which flips every bit at once and exposes any bit that is taken from the wrong sample.

Each pattern runs with a faster destination clock, a much slower one, and an equal one with an offset. This separates errors in the request path from errors in the acknowledge path. Every delivery is compared in order against the captured value. The bench also checks that captures never overtake deliveries and that the output holds between strobes.

// File: rtl/hs_value_sync_pkg.sv
package hs_value_sync_pkg;
  typedef enum logic [1:0] {
    SRC_CAPTURE  = 2'd0,
    SRC_WAIT_ACK = 2'd1,
    SRC_WAIT_REL = 2'd2
  } src_state_e;

  typedef enum logic {
    DST_IDLE = 1'b0,
    DST_ACK  = 1'b1
  } dst_state_e;
endpackage

// File: rtl/hs_sync_ff.sv
module hs_sync_ff #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[i] <= 1'b0;
          else         chain_q[i] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[i] <= 1'b0;
          else         chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/hs_src_ctrl.sv
module hs_src_ctrl
  import hs_value_sync_pkg::*;
#(
  parameter int W = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] value_i,
  input  logic         ack_sync_i,
  output logic         req_o,
  output logic [W-1:0] hold_o,
  output logic         take_o
);
  src_state_e   state_q, state_d;
  logic         req_q, req_d;
  logic [W-1:0] hold_q, hold_d;

  always_comb begin
    state_d = state_q;
    req_d   = req_q;
    hold_d  = hold_q;
    unique case (state_q)
      SRC_CAPTURE: begin
        hold_d  = value_i;
        req_d   = 1'b1;
        state_d = SRC_WAIT_ACK;
      end
      SRC_WAIT_ACK: begin
        if (ack_sync_i) begin
          req_d   = 1'b0;
          state_d = SRC_WAIT_REL;
        end
      end
      SRC_WAIT_REL: begin
        if (!ack_sync_i) state_d = SRC_CAPTURE;
      end
      default: state_d = SRC_CAPTURE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SRC_CAPTURE;
      req_q   <= 1'b0;
      hold_q  <= '0;
    end else begin
      state_q <= state_d;
      req_q   <= req_d;
      hold_q  <= hold_d;
    end
  end

  assign req_o  = req_q;
  assign hold_o = hold_q;
  assign take_o = (state_q == SRC_CAPTURE);
endmodule

// File: rtl/hs_dst_ctrl.sv
module hs_dst_ctrl
  import hs_value_sync_pkg::*;
#(
  parameter int W = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         req_sync_i,
  input  logic [W-1:0] hold_i,
  output logic         ack_o,
  output logic [W-1:0] value_o,
  output logic         valid_o
);
  dst_state_e   state_q, state_d;
  logic         ack_q, ack_d;
  logic         valid_q, valid_d;
  logic [W-1:0] value_q, value_d;

  always_comb begin
    state_d = state_q;
    ack_d   = ack_q;
    valid_d = 1'b0;
    value_d = value_q;
    unique case (state_q)
      DST_IDLE: begin
        if (req_sync_i) begin
          value_d = hold_i;   // hold_i is stable while the request is up
          valid_d = 1'b1;
          ack_d   = 1'b1;
          state_d = DST_ACK;
        end
      end
      DST_ACK: begin
        if (!req_sync_i) begin
          ack_d   = 1'b0;
          state_d = DST_IDLE;
        end
      end
      default: state_d = DST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= DST_IDLE;
      ack_q   <= 1'b0;
      valid_q <= 1'b0;
      value_q <= '0;
    end else begin
      state_q <= state_d;
      ack_q   <= ack_d;
      valid_q <= valid_d;
      value_q <= value_d;
    end
  end

  assign ack_o   = ack_q;
  assign value_o = value_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/hs_value_sync.sv
module hs_value_sync #(
  parameter int W           = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic         src_clk_i,
  input  logic         dst_clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] src_value_i,
  output logic         src_take_o,
  output logic [W-1:0] dst_value_o,
  output logic         dst_valid_o
);
  logic         src_req;
  logic [W-1:0] src_hold;
  logic         src_ack_sync;
  logic         dst_req_sync;
  logic         dst_ack;

  hs_src_ctrl #(.W(W)) u_src (
    .clk_i      (src_clk_i),
    .rst_ni     (rst_ni),
    .value_i    (src_value_i),
    .ack_sync_i (src_ack_sync),
    .req_o      (src_req),
    .hold_o     (src_hold),
    .take_o     (src_take_o)
  );

  hs_sync_ff #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk_i  (dst_clk_i),
    .rst_ni (rst_ni),
    .d_i    (src_req),
    .q_o    (dst_req_sync)
  );

  hs_dst_ctrl #(.W(W)) u_dst (
    .clk_i      (dst_clk_i),
    .rst_ni     (rst_ni),
    .req_sync_i (dst_req_sync),
    .hold_i     (src_hold),
    .ack_o      (dst_ack),
    .value_o    (dst_value_o),
    .valid_o    (dst_valid_o)
  );

  hs_sync_ff #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk_i  (src_clk_i),
    .rst_ni (rst_ni),
    .d_i    (dst_ack),
    .q_o    (src_ack_sync)
  );
endmodule

// File: rtl/hs_value_sync_chk.sv
module hs_value_sync_chk #(
  parameter int W = 5
) (
  input logic         src_clk_i,
  input logic         dst_clk_i,
  input logic         rst_ni,
  input logic         src_take_o,
  input logic         src_req,
  input logic [W-1:0] src_hold,
  input logic         src_ack_sync,
  input logic [W-1:0] dst_value_o,
  input logic         dst_valid_o
);
  always_comb begin
    if (!rst_ni) begin
      a_reset_out_r1: assert (!dst_valid_o && dst_value_o == '0);
    end
  end

  p_hold_stable_r2: assert property (@(posedge src_clk_i) disable iff (!rst_ni)
    src_req |=> $stable(src_hold));

  p_valid_pulse_r3: assert property (@(posedge dst_clk_i) disable iff (!rst_ni)
    dst_valid_o |=> !dst_valid_o);

  p_value_match_r4: assert property (@(posedge dst_clk_i) disable iff (!rst_ni)
    dst_valid_o |-> dst_value_o == src_hold);

  p_no_recapture_r7: assert property (@(posedge src_clk_i) disable iff (!rst_ni)
    src_take_o |-> !src_ack_sync && !src_req);

  p_value_hold_r8: assert property (@(posedge dst_clk_i) disable iff (!rst_ni)
    !dst_valid_o |-> $stable(dst_value_o));
endmodule

bind hs_value_sync hs_value_sync_chk #(.W(W)) u_chk (
  .src_clk_i    (src_clk_i),
  .dst_clk_i    (dst_clk_i),
  .rst_ni       (rst_ni),
  .src_take_o   (src_take_o),
  .src_req      (src_req),
  .src_hold     (src_hold),
  .src_ack_sync (src_ack_sync),
  .dst_value_o  (dst_value_o),
  .dst_valid_o  (dst_valid_o)
);

// File: tb/hs_value_sync_bench.sv
module hs_value_sync_bench;
  localparam int W = 5;
  localparam int QD = 64;

  logic         src_clk = 1'b0;
  logic         dst_clk = 1'b0;
  logic         rst_ni  = 1'b0;
  logic [W-1:0] src_value_i = '0;
  logic         src_take_o;
  logic [W-1:0] dst_value_o;
  logic         dst_valid_o;

  int checks = 0;
  int errors = 0;
  int dst_half = 3;
  int mode = 0;
  int taken = 0;
  int delivered = 0;
  int dst_edges = 0;
  int src_cycles = 0;
  logic [W-1:0] exp_q [QD];
  int           cap_edge [QD];
  logic [W-1:0] last_val = '0;
  logic         prev_valid = 1'b0;
  bit           done = 1'b0;

  hs_value_sync #(.W(W)) u_hs_value_sync (
    .src_clk_i   (src_clk),
    .dst_clk_i   (dst_clk),
    .rst_ni      (rst_ni),
    .src_value_i (src_value_i),
    .src_take_o  (src_take_o),
    .dst_value_o (dst_value_o),
    .dst_valid_o (dst_valid_o)
  );

  always #5 src_clk = ~src_clk;
  initial begin
    #3;
    forever #(dst_half) dst_clk = ~dst_clk;
  end

  always @(posedge dst_clk) dst_edges++;

  // Source side: pick next value, then record it if this cycle captures.
  always @(negedge src_clk) begin
    if (rst_ni && !done) begin
      logic [W-1:0] nv;
      case (mode)
        0:       nv = src_value_i + 1'b1;
        1:       nv = src_value_i * 5'd13 + 5'd7;
        default: nv = ~src_value_i;
      endcase
      src_value_i = nv;
      src_cycles++;
      if (src_take_o) begin
        checks++;
        if (taken != delivered) begin
          errors++;
          $display("FAIL R7 capture before delivery: taken %0d delivered %0d expected equal", taken, delivered);
        end
        exp_q[taken % QD]    = nv;
        cap_edge[taken % QD] = dst_edges;
        taken++;
      end
    end
  end

  // Destination side scoreboard.
  always @(negedge dst_clk) begin
    if (rst_ni && !done) begin
      if (dst_valid_o) begin
        checks++;
        if (prev_valid) begin
          errors++;
          $display("FAIL R3 valid high two cycles: actual 1 expected 0");
        end
        if (delivered >= taken) begin
          errors++;
          $display("FAIL R4 delivery without capture: delivered %0d taken %0d", delivered, taken);
        end else begin
          checks++;
          if (dst_value_o !== exp_q[delivered % QD]) begin
            errors++;
            $display("FAIL R4/R5 mode %0d value: actual %0h expected %0h", mode, dst_value_o, exp_q[delivered % QD]);
          end
          checks++;
          if (dst_edges - cap_edge[delivered % QD] < 2) begin
            errors++;
            $display("FAIL R6 latency: actual %0d dst edges expected >= 2", dst_edges - cap_edge[delivered % QD]);
          end
        end
        delivered++;
        last_val = dst_value_o;
      end else if (dst_value_o !== last_val) begin
        errors++;
        $display("FAIL R8 value changed without valid: actual %0h expected %0h", dst_value_o, last_val);
      end
      prev_valid = dst_valid_o;
    end
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge src_clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge src_clk);
    checks++;
    if (dst_valid_o !== 1'b0 || dst_value_o !== '0) begin  // R1
      errors++;
      $display("FAIL R1 reset outputs: actual valid %0b value %0h expected 0 0", dst_valid_o, dst_value_o);
    end
    rst_ni = 1'b1;
    // R9: fast, slow, equal-with-offset destination clocks
    for (int r = 0; r < 3; r++) begin
      dst_half = (r == 0) ? 3 : (r == 1) ? 27 : 5;
      for (int m = 0; m < 3; m++) begin
        int target;
        mode = m;
        target = delivered + 24;
        while (delivered < target) @(negedge src_clk);
      end
    end
    done = 1'b1;
    checks++;
    if (taken - delivered > 1) begin
      errors++;
      $display("FAIL R4 lost transfers: actual %0d pending expected <= 1", taken - delivered);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule